// File: doc/BRIEF.md
# BCD Digit to Ten-Line Decoder

This block accepts one binary-coded decimal digit on a 4-bit input and selects one of ten output lines. The line selected is the one whose index equals the digit's value. The digit's most significant bit sits at bit 3. In the default polarity the selected line is driven low and the other nine stay high. This suits loads that are enabled by pulling a line down.

The six codes above nine are not decimal digits. When one of them arrives, the block leaves every line in its idle level and raises a separate active-high flag. A parameter can flip the polarity of the lines. With it flipped, the chosen line goes high and idle lines sit low. Both the lines and the flag are registered. A code sampled at one rising edge therefore appears on the outputs after that edge, and both outputs always describe the same input sample.

Top module: `bcd_line_decoder`

## Requirements
- R1: While the synchronous reset is high at a rising edge, after that edge every line is at its idle level (all ones for active-low, all zeros for active-high) and the invalid flag is 0.
- R2: The outputs after a rising edge depend only on the digit sampled at that edge, giving exactly one cycle of latency.
- R3: For an input code from 0 to 9, exactly one line is in its active level, and the index of that line equals the code's value.
- R4: Code 0011 activates only line 3 and code 1000 activates only line 8. The range ends also hold: code 0000 activates only line 0 and code 1001 activates only line 9.
- R5: For any input code from 1010 to 1111, no line is in its active level.
- R6: The invalid flag is 1 in exactly the cycles whose lines came from a code of 10 or more, and 0 otherwise.
- R7: At no time is more than one line in its active level.
- R8: With the polarity parameter set to active-high, the selected line is 1 and the others are 0, and an invalid code drives all lines to 0. In the default active-low mode, the active level is 0 and the idle level is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| digit_in | input | 4 | BCD code, bit 3 most significant |
| line_out | output | 10 | Decoded lines, bit i is line i, polarity set by parameter |
| bad_code | output | 1 | High when the registered code was 10 to 15 |

## Verification
The decoding of lines and the rejection of invalid codes both update on the same edge from the same sample. The hazard is that the flag and the lines disagree for a cycle. To provoke this, the bench drives back-to-back codes that cross the boundary in both directions (9 to 10, 15 to 0, 10 to 9) on consecutive edges. After each edge it compares the ten lines and the flag together against the single code sampled at that edge. Both polarity builds run side by side on the same input, so every code is also judged against the mirrored encoding.

// File: rtl/bcd_dec_pkg.sv
package bcd_dec_pkg;
  typedef enum logic {POL_LOW = 1'b0, POL_HIGH = 1'b1} line_pol_e;
  localparam int DEC_LINES  = 10;
  localparam int DEC_CODE_W = 4;
endpackage

// File: rtl/bcd_code_check.sv
module bcd_code_check #(
  parameter int CODE_W = 4,
  parameter int LINES  = 10
) (
  input  logic [CODE_W-1:0] code,
  output logic              in_range
);
  localparam logic [CODE_W:0] LIMIT = (CODE_W+1)'(LINES);
  always_comb in_range = ({1'b0, code} < LIMIT);
endmodule

// File: rtl/bcd_line_select.sv
module bcd_line_select #(
  parameter int CODE_W = 4,
  parameter int LINES  = 10
) (
  input  logic [CODE_W-1:0] code,
  input  logic              in_range,
  output logic [LINES-1:0]  hot
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    localparam logic [CODE_W-1:0] MATCH = CODE_W'(i);
    assign hot[i] = in_range && (code == MATCH);
  end
endmodule

// File: rtl/bcd_out_stage.sv
module bcd_out_stage
  import bcd_dec_pkg::*;
#(
  parameter int        LINES = 10,
  parameter line_pol_e POL   = POL_LOW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] hot,
  input  logic             in_range,
  output logic [LINES-1:0] lines_q,
  output logic             invalid_q
);
  localparam logic [LINES-1:0] IDLE = (POL == POL_LOW) ? {LINES{1'b1}} : {LINES{1'b0}};

  always_ff @(posedge clk) begin
    if (rst) begin
      lines_q   <= IDLE;
      invalid_q <= 1'b0;
    end else begin
      lines_q   <= (POL == POL_LOW) ? ~hot : hot;
      invalid_q <= ~in_range;
    end
  end
endmodule

// File: rtl/bcd_line_decoder.sv
module bcd_line_decoder
  import bcd_dec_pkg::*;
#(
  parameter int        CODE_W = DEC_CODE_W,
  parameter int        LINES  = DEC_LINES,
  parameter line_pol_e POL    = POL_LOW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] digit_in,
  output logic [LINES-1:0]  line_out,
  output logic              bad_code
);
  logic             in_range;
  logic [LINES-1:0] hot;

  bcd_code_check #(.CODE_W(CODE_W), .LINES(LINES)) u_check (
    .code(digit_in), .in_range(in_range)
  );

  bcd_line_select #(.CODE_W(CODE_W), .LINES(LINES)) u_select (
    .code(digit_in), .in_range(in_range), .hot(hot)
  );

  bcd_out_stage #(.LINES(LINES), .POL(POL)) u_stage (
    .clk(clk), .rst(rst), .hot(hot), .in_range(in_range),
    .lines_q(line_out), .invalid_q(bad_code)
  );
endmodule

// File: rtl/bcd_line_decoder_chk.sv
module bcd_line_decoder_chk
  import bcd_dec_pkg::*;
#(
  parameter int        CODE_W = 4,
  parameter int        LINES  = 10,
  parameter line_pol_e POL    = POL_LOW
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] digit_in,
  input logic [LINES-1:0]  line_out,
  input logic              bad_code
);
  logic [LINES-1:0]  act;
  logic [CODE_W-1:0] code_d;
  assign act = (POL == POL_LOW) ? ~line_out : line_out;
  always_ff @(posedge clk) code_d <= digit_in;

  // R7: never two active lines
  a_r7_single_active: assert property (@(posedge clk) disable iff (rst) $onehot0(act));
  // R5: invalid code leaves all lines idle
  a_r5_invalid_idle: assert property (@(posedge clk) disable iff (rst)
    bad_code |-> (act == '0));
  // R6: flag follows the range of the sampled code
  a_r6_flag_high: assert property (@(posedge clk) disable iff (rst)
    (int'(digit_in) >= LINES) |=> bad_code);
  a_r6_flag_low: assert property (@(posedge clk) disable iff (rst)
    (int'(digit_in) < LINES) |=> !bad_code);
  // R3: a valid code activates exactly its own line
  a_r3_count_one: assert property (@(posedge clk) disable iff (rst)
    (int'(digit_in) < LINES) |=> ($countones(act) == 1));
  a_r3_index: assert property (@(posedge clk) disable iff (rst)
    (int'(digit_in) < LINES) |=> (act == (LINES'(1) << code_d)));
endmodule

bind bcd_line_decoder bcd_line_decoder_chk #(.CODE_W(CODE_W), .LINES(LINES), .POL(POL)) u_chk (
  .clk(clk), .rst(rst), .digit_in(digit_in), .line_out(line_out), .bad_code(bad_code)
);

// File: tb/bcd_line_decoder_bench.sv
module bcd_line_decoder_bench;
  import bcd_dec_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] digit = 4'd0;
  logic [9:0] lines_lo, lines_hi;
  logic       bad_lo, bad_hi;
  int         n_checks = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  bcd_line_decoder u_bcd_line_decoder (
    .clk(clk), .rst(rst), .digit_in(digit), .line_out(lines_lo), .bad_code(bad_lo)
  );

  bcd_line_decoder #(.POL(POL_HIGH)) u_bcd_line_decoder_hi (
    .clk(clk), .rst(rst), .digit_in(digit), .line_out(lines_hi), .bad_code(bad_hi)
  );

  function automatic logic [9:0] exp_hot(input int code);
    logic [9:0] v = '0;
    for (int i = 0; i < 10; i++) if (code == i) v[i] = 1'b1;
    return v;
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive code away from the edge, sample one edge later
  task automatic apply(input int code);
    @(negedge clk) digit = 4'(code);
    @(posedge clk);
    #1;
  endtask

  task automatic judge(input string req, input int code);
    logic [9:0] h = exp_hot(code);
    logic       inv = (code >= 10);
    check({req, " low-lines"}, lines_lo, ~h);
    check({req, " high-lines"}, lines_hi, h);
    check({req, " flag"}, {9'd0, bad_lo}, {9'd0, inv});
    check({req, " flag-hi"}, {9'd0, bad_hi}, {9'd0, inv});
  endtask

  task automatic t_reset;
    rst = 1'b1;
    digit = 4'd5;
    @(posedge clk); @(posedge clk); #1;
    check("R1 low idle", lines_lo, 10'h3FF);
    check("R1 high idle", lines_hi, 10'h000);
    check("R1 flag", {9'd0, bad_lo}, 10'd0);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic t_examples;
    apply(3);  judge("R4 code3", 3);
    apply(8);  judge("R4 code8", 8);
    apply(0);  judge("R4 code0", 0);
    apply(9);  judge("R4 code9", 9);
  endtask

  task automatic t_sweep_valid;
    for (int c = 0; c < 10; c++) begin
      apply(c);
      judge("R3", c);
      check("R8 polarity mirror", lines_lo, ~lines_hi);
    end
  endtask

  task automatic t_invalid;
    for (int c = 10; c < 16; c++) begin
      apply(c);
      judge("R5 R6", c);
      check("R7 none active", ~lines_lo, 10'd0);
    end
  endtask

  task automatic t_boundary;
    int seq [6] = '{9, 10, 15, 0, 10, 9};
    foreach (seq[k]) begin
      apply(seq[k]);
      judge("R2 R6 boundary", seq[k]);
    end
  endtask

  task automatic t_latency;
    apply(2);
    @(negedge clk) digit = 4'd7;
    #1;
    check("R2 hold before edge", lines_lo, ~exp_hot(2));
    @(posedge clk); #1;
    judge("R2 after edge", 7);
  endtask

  task automatic t_reset_mid;
    apply(4);
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    check("R1 mid-run low", lines_lo, 10'h3FF);
    check("R1 mid-run high", lines_hi, 10'h000);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    t_reset;
    t_examples;
    t_sweep_valid;
    t_invalid;
    t_boundary;
    t_latency;
    t_reset_mid;
    finish_run;
  end

  initial begin
    #(8 * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run;
  end
endmodule